// File: doc/BRIEF.md
# Scaled float-to-integer converter

This block turns an IEEE-754 single-precision operand into a 32-bit integer. The result can be signed or unsigned. Before it rounds, the block multiplies the operand by two raised to a small signed scale exponent. This lets fixed-point values with a binary point inside the word come straight out of a float. Each operation carries its own rounding mode, so the conversion needs no shared rounding setting and changes none. Every result comes with a two-bit exception vector, which the surrounding logic can OR into its own sticky status.

Operations enter through a valid/ready handshake. The result lands in a single output register one clock after the operation is accepted. It stays there until the consumer takes it with `outReady`. The conversion is combinational between the input handshake and that register.

Top module: `f2i_top`

## Requirements
- R1: The operand is multiplied by 2^scale, where scale is a two's-complement value of SCALE_W bits (default 6, range -32..31), and only then rounded. For example, 0.75 with scale 2 gives 3, not 4.
- R2: The 2-bit `inRound` selects the rounding for that operation alone: 0 = nearest with ties to even, 1 = toward zero, 2 = toward +infinity, 3 = toward -infinity.
- R3: In signed mode (`inUnsigned`=0), a rounded value above 2^31-1 returns 0x7FFFFFFF and one below -2^31 returns 0x80000000. +infinity and -infinity saturate the same way. Each of these raises invalid.
- R4: In unsigned mode, a negative non-NaN operand is converted exactly as in signed mode. The two's-complement result is returned. Invalid is raised only if that result is nonzero, and a negative value that rounds to 0 returns 0 without invalid.
- R5: A NaN of either sign returns the positive saturation value (0x7FFFFFFF signed, 0xFFFFFFFF unsigned) and raises invalid.
- R6: In unsigned mode, a non-negative value above 2^32-1, or +infinity, returns 0xFFFFFFFF and raises invalid. Values up to 2^32-1 are exact.
- R7: `outFlags` bit 1 is invalid and bit 0 is inexact. Inexact is set when an in-range result differs from the scaled operand. It is never set together with invalid.
- R8: Denormal operands are converted exactly. A scaled value whose magnitude is below 1 yields 0, +1 or -1 according to the rounding mode, with inexact set.
- R9: While `rstN` is low, and after it rises, `outValid` is 0 and `inReady` is 1.
- R10: An operation accepted on a rising edge (`inValid` and `inReady` both high) appears on `outResult`/`outFlags` with `outValid`=1 after that edge. While `outValid`=1 and `outReady`=0, the output stays stable, `inReady` is 0, and new operands are not taken.
- R11: +0 and -0 return 0 with no flags in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation offered |
| inReady | output | 1 | Block can take an operation this cycle |
| inOperand | input | 32 | Single-precision operand |
| inScale | input | SCALE_W | Signed power-of-two scale applied before rounding |
| inRound | input | 2 | Rounding mode for this operation |
| inUnsigned | input | 1 | 1 = unsigned result, 0 = signed |
| outValid | output | 1 | Result register holds a result |
| outReady | input | 1 | Consumer takes the result |
| outResult | output | 32 | Integer result |
| outFlags | output | 2 | {invalid, inexact} |

## Verification
The embedded assertions watch several things on every cycle:
- invalid and inexact never appear together;
- a held result never moves under backpressure;
- an accepted operation always produces a valid result;
- a signed NaN always saturates positive;
- an unsigned negative value that rounds to zero never raises invalid.

Other behaviour can only be shown by the bench's vectors, each checked against a hand-computed value:
- that scaling happens before rounding;
- the exact rounding in each of the four modes;
- the saturation boundaries at 2^31 and 2^32;
- the treatment of denormals and of negative unsigned inputs.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

  localparam int EXP_W     = 8;
  localparam int FRAC_W    = 23;
  localparam int MANT_W    = FRAC_W + 1;
  localparam int BIAS      = 127;
  localparam int INT_W     = 32;
  localparam int MAG_W     = INT_W + 1;
  // right shifts beyond this leave only sticky information
  localparam int SHIFT_CAP = MANT_W + 2;
  localparam int SHIFT_W   = $clog2(SHIFT_CAP + 1);
  localparam int WIDE_W    = MANT_W + SHIFT_CAP;
  // a left shift of this many places already reaches 2^32
  localparam int OVF_EXP   = INT_W - FRAC_W;
  localparam int EXT_W     = 12;

  typedef enum logic [1:0] {
    RND_NEAR = 2'd0,
    RND_ZERO = 2'd1,
    RND_UP   = 2'd2,
    RND_DOWN = 2'd3
  } rnd_e;

  typedef struct packed {
    logic invalid;
    logic inexact;
  } flags_t;

  typedef struct packed {
    logic load;
  } strobe_t;

endpackage

// File: rtl/f2i_align.sv
module f2i_align
  import f2i_pkg::*;
#(
  parameter int SCALE_W = 6
) (
  input  logic [31:0]        operand,
  input  logic [SCALE_W-1:0] scale,
  output logic [MAG_W-1:0]   intPart,
  output logic               roundBit,
  output logic               stickyBit,
  output logic               tooBig,
  output logic               isNan,
  output logic               isInf,
  output logic               isNeg
);

  logic [EXP_W-1:0]        expField;
  logic [FRAC_W-1:0]       fracField;
  logic [EXP_W-1:0]        expSel;
  logic [MANT_W-1:0]       mant;
  logic signed [EXT_W-1:0] scaleExt;
  logic signed [EXT_W-1:0] expEff;
  logic [EXT_W-1:0]        negE;
  logic [SHIFT_W-1:0]      shCap;
  logic [WIDE_W-1:0]       wide;

  assign expField  = operand[30:23];
  assign fracField = operand[22:0];
  assign isNeg     = operand[31];
  assign isNan     = (&expField) && (|fracField);
  assign isInf     = (&expField) && !(|fracField);

  always_comb begin
    expSel   = (expField == '0) ? EXP_W'(1) : expField;
    mant     = {(expField != '0), fracField};
    scaleExt = $signed({{(EXT_W-SCALE_W){scale[SCALE_W-1]}}, scale});
    // weight of the mantissa LSB after scaling
    expEff   = $signed({{(EXT_W-EXP_W){1'b0}}, expSel})
             - $signed(EXT_W'(BIAS + FRAC_W)) + scaleExt;
    negE     = EXT_W'(-expEff);
    shCap    = (negE > EXT_W'(SHIFT_CAP)) ? SHIFT_W'(SHIFT_CAP) : negE[SHIFT_W-1:0];
    wide     = {mant, {SHIFT_CAP{1'b0}}} >> shCap;

    intPart   = '0;
    roundBit  = 1'b0;
    stickyBit = 1'b0;
    tooBig    = 1'b0;
    if (expEff < 0) begin
      intPart   = MAG_W'(wide[WIDE_W-1:SHIFT_CAP]);
      roundBit  = wide[SHIFT_CAP-1];
      stickyBit = |wide[SHIFT_CAP-2:0];
    end else begin
      tooBig = (expEff >= EXT_W'(OVF_EXP));
      if (!tooBig) intPart = MAG_W'(mant) << expEff[3:0];
    end
  end

endmodule

// File: rtl/f2i_datapath.sv
module f2i_datapath
  import f2i_pkg::*;
#(
  parameter int SCALE_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic [31:0]        operand,
  input  logic [SCALE_W-1:0] scale,
  input  logic [1:0]         rndMode,
  input  logic               unsignedMode,
  output logic [INT_W-1:0]   resultQ,
  output flags_t             flagsQ
);

  localparam logic [MAG_W-1:0] POS_LIM = MAG_W'(33'h0_7FFF_FFFF);
  localparam logic [MAG_W-1:0] NEG_LIM = MAG_W'(33'h0_8000_0000);
  localparam logic [INT_W-1:0] S_MAX   = 32'h7FFF_FFFF;
  localparam logic [INT_W-1:0] S_MIN   = 32'h8000_0000;
  localparam logic [INT_W-1:0] U_MAX   = 32'hFFFF_FFFF;

  logic [MAG_W-1:0] intPart;
  logic             roundBit, stickyBit, tooBig, isNan, isInf, isNeg;
  logic             lost, inc;
  logic [MAG_W-1:0] mag;
  logic             sOvf, uOvf;
  logic [INT_W-1:0] sRes, uRes, resD;
  flags_t           flagsD;

  f2i_align #(.SCALE_W(SCALE_W)) uAlign (
    .operand  (operand),
    .scale    (scale),
    .intPart  (intPart),
    .roundBit (roundBit),
    .stickyBit(stickyBit),
    .tooBig   (tooBig),
    .isNan    (isNan),
    .isInf    (isInf),
    .isNeg    (isNeg)
  );

  // rounding increment chosen by the per-operation mode
  always_comb begin
    lost = roundBit | stickyBit;
    case (rnd_e'(rndMode))
      RND_NEAR: inc = roundBit & (stickyBit | intPart[0]);
      RND_ZERO: inc = 1'b0;
      RND_UP:   inc = !isNeg & lost;
      RND_DOWN: inc = isNeg & lost;
      default:  inc = 1'b0;
    endcase
    mag = intPart + MAG_W'(inc);
  end

  // signed and unsigned saturation
  always_comb begin
    sOvf = isNan | isInf | tooBig | (isNeg ? (mag > NEG_LIM) : (mag > POS_LIM));
    if (isNan)      sRes = S_MAX;
    else if (sOvf)  sRes = isNeg ? S_MIN : S_MAX;
    else if (isNeg) sRes = INT_W'(-mag[INT_W-1:0]);
    else            sRes = mag[INT_W-1:0];

    uOvf = isNan | isInf | tooBig | mag[MAG_W-1];
    uRes = uOvf ? U_MAX : mag[INT_W-1:0];
  end

  // mode select, including the negative-unsigned rule
  always_comb begin
    if (!unsignedMode) begin
      resD           = sRes;
      flagsD.invalid = sOvf;
      flagsD.inexact = !sOvf & lost;
    end else if (isNeg && !isNan) begin
      resD           = sRes;
      flagsD.invalid = (sRes != '0);
      flagsD.inexact = (sRes == '0) & lost;
    end else begin
      resD           = uRes;
      flagsD.invalid = uOvf;
      flagsD.inexact = !uOvf & lost;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
      flagsQ  <= '0;
    end else if (strobe.load) begin
      resultQ <= resD;
      flagsQ  <= flagsD;
    end
  end

  assert_nan_signed_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && isNan && !unsignedMode) |=> (resultQ == S_MAX) && flagsQ.invalid);

  assert_neg_zero_uns_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && unsignedMode && isNeg && !isNan && !isInf && !tooBig && (mag == '0))
      |=> (resultQ == '0) && !flagsQ.invalid);

  assert_flag_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    flagsQ.invalid |-> !flagsQ.inexact);

endmodule

// File: rtl/f2i_ctrl.sv
module f2i_ctrl
  import f2i_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  input  logic    outReady,
  output logic    inReady,
  output logic    outValid,
  output strobe_t strobe
);

  assign inReady     = !outValid || outReady;
  assign strobe.load = inValid && inReady;

  always_ff @(posedge clk) begin
    if (!rstN)            outValid <= 1'b0;
    else if (strobe.load) outValid <= 1'b1;
    else if (outReady)    outValid <= 1'b0;
  end

  assert_accept_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> outValid);

endmodule

// File: rtl/f2i_top.sv
module f2i_top
  import f2i_pkg::*;
#(
  parameter int SCALE_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [31:0]        inOperand,
  input  logic [SCALE_W-1:0] inScale,
  input  logic [1:0]         inRound,
  input  logic               inUnsigned,
  output logic               outValid,
  input  logic               outReady,
  output logic [31:0]        outResult,
  output logic [1:0]         outFlags
);

  strobe_t strobe;
  flags_t  flagsQ;

  f2i_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .outReady(outReady),
    .inReady (inReady),
    .outValid(outValid),
    .strobe  (strobe)
  );

  f2i_datapath #(.SCALE_W(SCALE_W)) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .operand     (inOperand),
    .scale       (inScale),
    .rndMode     (inRound),
    .unsignedMode(inUnsigned),
    .resultQ     (outResult),
    .flagsQ      (flagsQ)
  );

  assign outFlags = flagsQ;

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid && $stable(outResult) && $stable(outFlags));

endmodule

// File: tb/sim_f2i_top.sv
`timescale 1ns/1ps
module sim_f2i_top;

  localparam int SCALE_W = 6;
  localparam int NVEC    = 34;
  // {tag[24], operand[32], scale[6], round[2], uns[1], result[32], flags[2]}
  localparam logic [98:0] VEC [NVEC] = '{
    {"R2 ", 32'h3F80_0000, 6'd0,  2'd0, 1'b0, 32'h0000_0001, 2'b00},
    {"R1 ", 32'h3F40_0000, 6'd2,  2'd0, 1'b0, 32'h0000_0003, 2'b00},
    {"R2 ", 32'h3FC0_0000, 6'd0,  2'd0, 1'b0, 32'h0000_0002, 2'b01},
    {"R2 ", 32'h4020_0000, 6'd0,  2'd0, 1'b0, 32'h0000_0002, 2'b01},
    {"R2 ", 32'h4020_0000, 6'd0,  2'd1, 1'b0, 32'h0000_0002, 2'b01},
    {"R2 ", 32'h4020_0000, 6'd0,  2'd2, 1'b0, 32'h0000_0003, 2'b01},
    {"R2 ", 32'hC020_0000, 6'd0,  2'd3, 1'b0, 32'hFFFF_FFFD, 2'b01},
    {"R2 ", 32'hC020_0000, 6'd0,  2'd2, 1'b0, 32'hFFFF_FFFE, 2'b01},
    {"R1 ", 32'h3F80_0000, 6'h3F, 2'd0, 1'b0, 32'h0000_0000, 2'b01},
    {"R3 ", 32'h3F80_0000, 6'd31, 2'd0, 1'b0, 32'h7FFF_FFFF, 2'b10},
    {"R3 ", 32'hBF80_0000, 6'd31, 2'd0, 1'b0, 32'h8000_0000, 2'b00},
    {"R6 ", 32'h3F80_0000, 6'd31, 2'd0, 1'b1, 32'h8000_0000, 2'b00},
    {"R6 ", 32'h4000_0000, 6'd31, 2'd0, 1'b1, 32'hFFFF_FFFF, 2'b10},
    {"R3 ", 32'h7F80_0000, 6'd0,  2'd0, 1'b0, 32'h7FFF_FFFF, 2'b10},
    {"R3 ", 32'hFF80_0000, 6'd0,  2'd0, 1'b0, 32'h8000_0000, 2'b10},
    {"R5 ", 32'h7FC0_0000, 6'd0,  2'd0, 1'b0, 32'h7FFF_FFFF, 2'b10},
    {"R5 ", 32'hFFC0_0000, 6'd0,  2'd1, 1'b1, 32'hFFFF_FFFF, 2'b10},
    {"R4 ", 32'hBF80_0000, 6'd0,  2'd0, 1'b1, 32'hFFFF_FFFF, 2'b10},
    {"R4 ", 32'hBE80_0000, 6'd0,  2'd1, 1'b1, 32'h0000_0000, 2'b01},
    {"R4 ", 32'hBF40_0000, 6'd0,  2'd0, 1'b1, 32'hFFFF_FFFF, 2'b10},
    {"R8 ", 32'h0000_0001, 6'd0,  2'd2, 1'b0, 32'h0000_0001, 2'b01},
    {"R8 ", 32'h0000_0001, 6'd0,  2'd0, 1'b0, 32'h0000_0000, 2'b01},
    {"R8 ", 32'h8000_0001, 6'd0,  2'd3, 1'b0, 32'hFFFF_FFFF, 2'b01},
    {"R8 ", 32'h8000_0001, 6'd0,  2'd3, 1'b1, 32'hFFFF_FFFF, 2'b10},
    {"R11", 32'h8000_0000, 6'd0,  2'd0, 1'b0, 32'h0000_0000, 2'b00},
    {"R11", 32'h0000_0000, 6'd0,  2'd0, 1'b1, 32'h0000_0000, 2'b00},
    {"R1 ", 32'h4060_0000, 6'h3F, 2'd0, 1'b0, 32'h0000_0002, 2'b01},
    {"R1 ", 32'h42F6_0000, 6'd3,  2'd0, 1'b0, 32'h0000_03D8, 2'b00},
    {"R7 ", 32'h3F00_0000, 6'd0,  2'd0, 1'b0, 32'h0000_0000, 2'b01},
    {"R6 ", 32'h4F7F_FFFF, 6'd0,  2'd0, 1'b1, 32'hFFFF_FF00, 2'b00},
    {"R3 ", 32'hCF00_0001, 6'd0,  2'd0, 1'b0, 32'h8000_0000, 2'b10},
    {"R8 ", 32'h4F00_0000, 6'h20, 2'd2, 1'b0, 32'h0000_0001, 2'b01},
    {"R6 ", 32'h7F80_0000, 6'd0,  2'd0, 1'b1, 32'hFFFF_FFFF, 2'b10},
    {"R8 ", 32'hBE80_0000, 6'd0,  2'd2, 1'b0, 32'h0000_0000, 2'b01}
  };

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               inValid = 1'b0;
  logic               inReady;
  logic [31:0]        inOperand = '0;
  logic [SCALE_W-1:0] inScale = '0;
  logic [1:0]         inRound = '0;
  logic               inUnsigned = 1'b0;
  logic               outValid;
  logic               outReady = 1'b1;
  logic [31:0]        outResult;
  logic [1:0]         outFlags;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  f2i_top #(.SCALE_W(SCALE_W)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inOperand(inOperand), .inScale(inScale), .inRound(inRound),
    .inUnsigned(inUnsigned), .outValid(outValid), .outReady(outReady),
    .outResult(outResult), .outFlags(outFlags)
  );

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9", {34'd0, outValid, inReady}, {34'd0, 1'b0, 1'b1});
    rstN = 1'b1;
    @(negedge clk);
    check("R9", {34'd0, outValid, inReady}, {34'd0, 1'b0, 1'b1});

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      inOperand  = VEC[i][74:43];
      inScale    = VEC[i][42:37];
      inRound    = VEC[i][36:35];
      inUnsigned = VEC[i][34];
      inValid    = 1'b1;
      @(negedge clk);
      inValid = 1'b0;
      check(string'(VEC[i][98:75]), {1'b0, outValid, outResult, outFlags},
            {1'b0, 1'b1, VEC[i][33:2], VEC[i][1:0]});
    end

    // R10: backpressure and hold
    @(negedge clk);
    outReady = 1'b0;
    inOperand = 32'h3F80_0000; inScale = '0; inRound = 2'd0; inUnsigned = 1'b0;
    inValid = 1'b1;
    @(negedge clk);
    check("R10", {2'b0, outValid, inReady, outResult}, {2'b0, 1'b1, 1'b0, 32'd1});
    inOperand = 32'h4000_0000;
    @(negedge clk);
    check("R10", {1'b0, outValid, outResult, outFlags}, {1'b0, 1'b1, 32'd1, 2'b00});
    outReady = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check("R10", {1'b0, outValid, outResult, outFlags}, {1'b0, 1'b1, 32'd2, 2'b00});
    @(negedge clk);
    check("R10", {34'd0, outValid, inReady}, {34'd0, 1'b0, 1'b1});

    // R2: mode of one operation leaves the next unaffected
    inOperand = 32'h4020_0000; inRound = 2'd2; inValid = 1'b1;
    @(negedge clk);
    inRound = 2'd0;
    @(negedge clk);
    inValid = 1'b0;
    check("R2", {2'b0, outResult, outFlags}, {2'b0, 32'd2, 2'b01});

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule